// File: doc/BRIEF.md
# Bus Address Reference Counter Bank

This block watches a 16-bit bus address together with a master-sync strobe and counts how often each of eight programmable address groups is referenced. Each group holds a compare value and a don't-care mask. A group can therefore cover one address or any aligned power-of-two block. A host loads each group through a small write port that selects the group with a 3-bit index.

When the strobe rises, every group whose value agrees with the address on all cared-about bits raises a one-clock hit pulse. That pulse adds one to the group's 16-bit counter. Several overlapping groups can count the same bus cycle. A 3-bit view selector routes one group's count and its hit pulse to the outputs, for a display and for an external frequency meter. A single clear input zeroes every counter.

Top module: `addr_ref_counter`

## Requirements
- R1: After reset all eight counters read 0 and `view_pulse` is 0.
- R2: A group matches when `(bus_addr ^ value) & ~mask` is zero, where a mask bit of 1 marks that address bit as don't-care. Each match adds exactly 1 to that group's counter.
- R3: Only a low-to-high transition of `bus_sync` starts a reference, and it counts once however long the strobe stays high. Address changes while the strobe is low do not change any counter.
- R4: When one reference matches several groups, all of those groups count it.
- R5: A counter at 16'hFFFF wraps to 16'h0000 on its next increment.
- R6: `clear_all` sampled high at a clock edge sets every counter to 0, and wins over an increment due at the same edge.
- R7: `view_count` shows the counter of the group whose index is on `view_sel`.
- R8: `view_pulse` is high for exactly one clock, in the cycle after the edge that samples the strobe's rise. The selected counter shows the new value one cycle later.
- R9: With `cfg_we` high at a clock edge, group `cfg_idx` takes `cfg_value` and `cfg_mask`, and the other groups keep their settings. After reset every group has value 0 and mask 0, so it matches only address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Monitored bus address |
| bus_sync | input | 1 | Master-sync strobe qualifying the address |
| cfg_we | input | 1 | Group configuration write enable |
| cfg_idx | input | 3 | Group being configured |
| cfg_value | input | 16 | Compare value to load |
| cfg_mask | input | 16 | Don't-care mask to load (1 = ignore bit) |
| clear_all | input | 1 | Zero all counters |
| view_sel | input | 3 | Group routed to the view outputs |
| view_count | output | 16 | Count of the selected group |
| view_pulse | output | 1 | Hit pulse of the selected group |

## Verification
Assertions check the per-counter arithmetic on every cycle. A counter steps by exactly one after a hit, holds without a hit, wraps at the top, and is zero after a clear. They also check that each hit pulse lasts one clock and only while the strobe is held. The bench scenarios cover what needs knowledge of addresses: which groups a given address should hit under masks, overlap between groups, and configuration writes reaching only their target group. The scenarios also cover the exact cycle in which the view outputs change.

// File: rtl/addr_ref_counter.sv
module addr_ref_counter #(
  parameter int ADDR_W = 16,
  parameter int GROUPS = 8,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(GROUPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_sync,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_value,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic              clear_all,
  input  logic [IDX_W-1:0]  view_sel,
  output logic [CNT_W-1:0]  view_count,
  output logic              view_pulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              sync_q;
  logic              rise;
  logic [ADDR_W-1:0] grp_val  [GROUPS];
  logic [ADDR_W-1:0] grp_mask [GROUPS];
  logic [CNT_W-1:0]  cnt      [GROUPS];
  logic [GROUPS-1:0] hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= bus_sync;
  end

  assign rise = bus_sync & ~sync_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        grp_val[g]  <= '0;
        grp_mask[g] <= '0;
      end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
        grp_val[g]  <= cfg_value;
        grp_mask[g] <= cfg_mask;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) hit_q[g] <= 1'b0;
      else        hit_q[g] <= rise && (((bus_addr ^ grp_val[g]) & ~grp_mask[g]) == '0);
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clear_all) cnt[g] <= '0;
      else if (hit_q[g])       cnt[g] <= cnt[g] + 1'b1;
    end

    p_one_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q[g] |=> !hit_q[g]);
    p_hit_in_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q[g] |-> sync_q);
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q[g] && !clear_all) |=> cnt[g] == CNT_W'($past(cnt[g]) + 1'b1));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_q[g] && !clear_all) |=> $stable(cnt[g]));
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q[g] && !clear_all && cnt[g] == CNT_MAX) |=> cnt[g] == '0);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear_all |=> cnt[g] == '0);
  end

  assign view_count = cnt[view_sel];
  assign view_pulse = hit_q[view_sel];

  p_pulse_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(view_sel) && view_pulse && !clear_all) |=> view_count == CNT_W'($past(view_count) + 1'b1));

endmodule

// File: tb/addr_ref_counter_bench.sv
module addr_ref_counter_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic        bus_sync = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_idx = '0;
  logic [15:0] cfg_value = '0;
  logic [15:0] cfg_mask = '0;
  logic        clear_all = 0;
  logic [2:0]  view_sel = '0;
  logic [15:0] view_count;
  logic        view_pulse;

  addr_ref_counter u_addr_ref_counter (.*);

  always #5 clk = ~clk;

  typedef struct { int sel; logic [15:0] exp; string req; } item_t;
  item_t q[$];
  int issued = 0, done = 0;
  int n_cmp = 0, n_bad = 0;
  logic [15:0] m_val [8];
  logic [15:0] m_mask[8];
  logic [15:0] m_cnt [8];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected counts and compares against the view outputs
  initial forever begin
    item_t it;
    wait (q.size() > 0);
    it = q.pop_front();
    @(negedge clk) view_sel = 3'(it.sel);
    @(negedge clk) check(it.req, {16'h0, view_count}, {16'h0, it.exp});
    done++;
  end

  task automatic expect_cnt(int g, string req);
    q.push_back('{g, m_cnt[g], req});
    issued++;
    wait (done == issued);
  endtask

  task automatic expect_all(string req);
    for (int g = 0; g < 8; g++) expect_cnt(g, req);
  endtask

  function automatic void model_ref(logic [15:0] a);
    for (int g = 0; g < 8; g++)
      if (((a ^ m_val[g]) & ~m_mask[g]) == 16'h0) m_cnt[g] = m_cnt[g] + 16'h1;
  endfunction

  task automatic cfg(int idx, logic [15:0] v, logic [15:0] m);
    @(negedge clk) begin cfg_we = 1; cfg_idx = 3'(idx); cfg_value = v; cfg_mask = m; end
    @(negedge clk) cfg_we = 0;
    m_val[idx] = v; m_mask[idx] = m;
  endtask

  task automatic bus_cycle(logic [15:0] a, int hold);
    @(negedge clk) begin bus_addr = a; bus_sync = 1; end
    repeat (hold - 1) @(negedge clk);
    @(negedge clk) bus_sync = 0;
    model_ref(a);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int g = 0; g < 8; g++) begin m_val[g] = 0; m_mask[g] = 0; m_cnt[g] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 pulse idle", {31'h0, view_pulse}, 0);
    expect_all("R1 reset count");

    bus_cycle(16'h0000, 1);
    expect_all("R9 default match of address 0");

    cfg(0, 16'h1234, 16'h0000);
    cfg(1, 16'h1200, 16'h00FF);
    cfg(2, 16'h8000, 16'h7FFF);
    cfg(3, 16'h1234, 16'h000F);
    cfg(4, 16'hFFFF, 16'h0000);
    bus_cycle(16'h0000, 1);
    expect_all("R9 untouched groups keep config");
    for (int g = 5; g < 8; g++) cfg(g, 16'hFFFF, 16'h0000);

    bus_cycle(16'h1234, 1);
    expect_all("R4 overlapping groups");
    bus_cycle(16'h1299, 4);
    expect_all("R3 long strobe counts once");
    bus_cycle(16'h1235, 1);
    bus_cycle(16'h8ABC, 2);
    bus_cycle(16'h12FF, 1);
    bus_cycle(16'h1300, 1);
    expect_all("R2 masked matching");

    @(negedge clk) bus_addr = 16'h1234;
    repeat (3) @(negedge clk) bus_addr = bus_addr + 16'h1;
    expect_cnt(0, "R3 no strobe no count");
    expect_cnt(1, "R3 no strobe no count");

    // R8 pulse timing on group 2, R7 selection
    view_sel = 3'd2;
    @(negedge clk) begin bus_addr = 16'hC000; bus_sync = 1; end
    @(negedge clk) check("R8 count before step", {16'h0, view_count}, {16'h0, m_cnt[2]});
    check("R8 pulse high", {31'h0, view_pulse}, 1);
    @(negedge clk) check("R8 pulse one clock", {31'h0, view_pulse}, 0);
    model_ref(16'hC000);
    check("R7 count after step", {16'h0, view_count}, {16'h0, m_cnt[2]});
    bus_sync = 0;
    @(negedge clk);

    // R6 clear priority over pending increment
    @(negedge clk) begin bus_addr = 16'h1234; bus_sync = 1; end
    @(negedge clk) begin clear_all = 1; bus_sync = 0; end
    @(negedge clk) clear_all = 0;
    for (int g = 0; g < 8; g++) m_cnt[g] = 0;
    expect_all("R6 clear wins");

    // R5 wrap on group 7 (matches any address)
    cfg(7, 16'h0000, 16'hFFFF);
    @(negedge clk) bus_addr = 16'h4000;
    for (int i = 0; i < 65535; i++) begin
      @(negedge clk) bus_sync = 1;
      @(negedge clk) bus_sync = 0;
      model_ref(16'h4000);
    end
    repeat (2) @(negedge clk);
    expect_cnt(7, "R5 reach top");
    bus_cycle(16'h4000, 1);
    expect_cnt(7, "R5 wrap to zero");
    expect_cnt(0, "R2 no false match");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1900000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule